// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterized number of sources (16 by default) and presents one registered request line to a single processor core. Each source has a 3-bit priority level and a 2-bit detection mode. Every input passes through a two-flop synchronizer before detection. A detected event sets a sticky pending flag for that source. A combinational arbiter scans the pending flags and picks the highest level. When levels are equal, the lowest source index wins. The request line is raised only if the winning level is strictly above the current mask level.

When the core acknowledges a raised request, the controller accepts it:
- The winner's level is copied into the mask.
- The winner's vector (source index times 16) is copied into the vector register.
- The winner's pending flag is cleared.
- The controller locks.

While locked, nothing can raise the request line or modify the mask and vector through acceptance. The lock is released only when software reads the vector register over the register bus. The correct software order is therefore: read the vector first, then lower the mask.

A simple synchronous register bus is used to program per-source configuration, read the vector, read or write the mask, read the pending flags and clear pending flags with write-one-to-clear.

Top module: `pvic_top`

## Requirements
- R1: After reset the request line is low, and the vector, mask and pending registers all read as zero.
- R2: A source's detection mode is held in configuration bits [5:4]: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Its level is held in bits [2:0]. Inputs are synchronized by two flops before detection.
- R3: A source whose level is 0 never becomes pending and never raises a request. Setting a pending source's level to 0 drops its pending flag.
- R4: The request line goes high only when the highest pending level is strictly greater than the mask level and the controller is unlocked.
- R5: The highest pending level wins arbitration. Among equal levels, the lower source index wins.
- R6: A repeated request from a source that is already pending is absorbed into a single pending flag. Acceptance clears the winner's pending flag.
- R7: An acknowledge while the request line is high loads the mask with the winner's level and the vector with (winner index << 4). It also drops the request line on the next cycle.
- R8: After acceptance, the mask and vector are not reloaded and the request line stays low until the vector register is read. This holds even if the mask is written in the meantime.
- R9: Writing a 1 to bit i of the clear register removes source i's pending flag.
- R10: An acknowledge while the request line is low changes neither the mask nor the vector.
- R11: Register word map (byte address / 4):
  - 0 = vector (read; releases the lock)
  - 1 = mask (read/write, bits [2:0])
  - 2 = clear (write-one-to-clear)
  - 3 = pending (read)
  - 16+i = source i configuration
  
  Read data appears one cycle after the request, with a valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw interrupt inputs, one per source |
| irq_o | output | 1 | Registered request line to the core |
| irq_ack_i | input | 1 | Acknowledge pulse from the core |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |

## Verification
The hardest situation to reach from the ports is a locked controller that has a higher-level request pending behind the lock. In that state the request line must stay low and the mask must hold. The line must rise only after the vector read.

The stimulus gets there in three steps:
1. Accept a low-level source.
2. Pulse a level-7 edge source and confirm through the pending register that it is queued.
3. Check that the request line stays low.

A second sequence writes the mask to zero while still locked, before reading the vector. It confirms that no spurious request appears until the read.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    typedef enum logic [1:0] {
        DET_LOW  = 2'd0,
        DET_HIGH = 2'd1,
        DET_RISE = 2'd2,
        DET_FALL = 2'd3
    } det_mode_e;

    localparam int WORD_VEC  = 0;
    localparam int WORD_MASK = 1;
    localparam int WORD_CLR  = 2;
    localparam int WORD_PEND = 3;
    localparam int WORD_CFG  = 16;
endpackage

// File: rtl/pvic_sync_det.sv
module pvic_sync_det #(
    parameter int NUM_SRC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_i,
    input  logic [NUM_SRC-1:0][1:0] mode_i,
    output logic [NUM_SRC-1:0]      det_o
);
    import pvic_pkg::*;

    logic [NUM_SRC-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= src_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_det
        always_comb begin
            unique case (det_mode_e'(mode_i[i]))
                DET_LOW:  det_o[i] = ~s2_q[i];
                DET_HIGH: det_o[i] =  s2_q[i];
                DET_RISE: det_o[i] =  s2_q[i] & ~s3_q[i];
                DET_FALL: det_o[i] = ~s2_q[i] &  s3_q[i];
                default:  det_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    output logic                          win_valid_o,
    output logic [IDX_W-1:0]              win_idx_o,
    output logic [LVL_W-1:0]              win_lvl_o
);
    // Ascending scan with strict compare keeps the lower index on ties.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (lvl_i[i] > win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_lvl_o   = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/pvic_bus_dec.sv
module pvic_bus_dec #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 8,
    localparam int WORD_W = ADDR_W - 2,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              rd_o,
    output logic              rd_vec_o,
    output logic              wr_mask_o,
    output logic              wr_clr_o,
    output logic              wr_cfg_o,
    output logic [IDX_W-1:0]  cfg_idx_o
);
    import pvic_pkg::*;

    logic [1:0]  byte_off;
    logic        cfg_hit;
    logic [WORD_W-1:0] cfg_rel;

    always_comb begin
        byte_off  = addr_i[1:0];
        word_o    = addr_i[ADDR_W-1:2];
        cfg_rel   = word_o - WORD_W'(WORD_CFG);
        cfg_hit   = (byte_off == 2'b00)
                  && (int'(word_o) >= WORD_CFG)
                  && (int'(word_o) <  WORD_CFG + NUM_SRC);
        cfg_idx_o = cfg_rel[IDX_W-1:0];
        rd_o      = req_i && !we_i;
        rd_vec_o  = rd_o && (int'(word_o) == WORD_VEC);
        wr_mask_o = req_i && we_i && (int'(word_o) == WORD_MASK);
        wr_clr_o  = req_i && we_i && (int'(word_o) == WORD_CLR);
        wr_cfg_o  = req_i && we_i && cfg_hit;
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
    parameter int NUM_SRC   = 16,
    parameter int LVL_W     = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int VEC_SHIFT = 4,
    localparam int IDX_W    = $clog2(NUM_SRC),
    localparam int WORD_W   = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    input  logic               irq_ack_i,
    input  logic               bus_req_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o
);
    import pvic_pkg::*;

    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
        logic [NUM_SRC-1:0][1:0]       mode;
        logic [NUM_SRC-1:0]            pend;
        logic [LVL_W-1:0]              mask;
        logic [DATA_W-1:0]             vec;
        logic                          lock;
        logic                          irq;
        logic [DATA_W-1:0]             rdata;
        logic                          rvalid;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] det;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [WORD_W-1:0]  word;
    logic               rd, rd_vec, wr_mask, wr_clr, wr_cfg;
    logic [IDX_W-1:0]   cfg_idx;
    logic               accept;
    logic [NUM_SRC-1:0] lvl_nz;

    // Plain views of state used by the bound checker.
    logic               lock_w;
    logic [LVL_W-1:0]   mask_w;
    logic [DATA_W-1:0]  vec_w;
    assign lock_w = st_q.lock;
    assign mask_w = st_q.mask;
    assign vec_w  = st_q.vec;

    pvic_sync_det #(.NUM_SRC(NUM_SRC)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .mode_i (st_q.mode),
        .det_o  (det)
    );

    pvic_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .pend_i      (st_q.pend),
        .lvl_i       (st_q.lvl),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    pvic_bus_dec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .word_o    (word),
        .rd_o      (rd),
        .rd_vec_o  (rd_vec),
        .wr_mask_o (wr_mask),
        .wr_clr_o  (wr_clr),
        .wr_cfg_o  (wr_cfg),
        .cfg_idx_o (cfg_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;

        for (int i = 0; i < NUM_SRC; i++) begin
            lvl_nz[i] = (st_q.lvl[i] != '0);
        end

        accept = irq_ack_i && st_q.irq && !st_q.lock && win_valid;

        // Pending flags: sticky, gated by nonzero level, cleared by W1C or acceptance.
        st_d.pend = (st_q.pend | det) & lvl_nz;
        if (wr_clr) begin
            st_d.pend = st_d.pend & ~bus_wdata_i[NUM_SRC-1:0];
        end
        if (accept) begin
            st_d.pend[win_idx] = 1'b0;
        end

        if (wr_cfg) begin
            st_d.lvl[cfg_idx]  = bus_wdata_i[LVL_W-1:0];
            st_d.mode[cfg_idx] = bus_wdata_i[5:4];
        end

        if (wr_mask) begin
            st_d.mask = bus_wdata_i[LVL_W-1:0];
        end

        if (accept) begin
            st_d.mask = win_lvl;
            st_d.vec  = DATA_W'(win_idx) << VEC_SHIFT;
            st_d.lock = 1'b1;
        end else if (rd_vec) begin
            st_d.lock = 1'b0;
        end

        st_d.irq = !st_q.lock && !accept && win_valid && (win_lvl > st_q.mask);

        if (rd) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = '0;
            if (int'(word) == WORD_VEC) begin
                st_d.rdata = st_q.vec;
            end else if (int'(word) == WORD_MASK) begin
                st_d.rdata = DATA_W'(st_q.mask);
            end else if (int'(word) == WORD_PEND) begin
                st_d.rdata = DATA_W'(st_q.pend);
            end else if ((int'(word) >= WORD_CFG) && (int'(word) < WORD_CFG + NUM_SRC)) begin
                st_d.rdata = DATA_W'({st_q.mode[cfg_idx], 1'b0, st_q.lvl[cfg_idx]});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o        = st_q.irq;
    assign bus_rdata_o  = st_q.rdata;
    assign bus_rvalid_o = st_q.rvalid;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
    parameter int LVL_W     = 3,
    parameter int DATA_W    = 32,
    parameter int VEC_SHIFT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              irq_ack,
    input logic              lock,
    input logic [LVL_W-1:0]  mask,
    input logic [DATA_W-1:0] vec,
    input logic              vec_rd,
    input logic              mask_wr
);
    // R7
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq && !lock) |=> (lock && (mask != '0) && (vec[VEC_SHIFT-1:0] == '0)));

    // R7
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq && !lock) |=> !irq);

    // R8
    locked_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !vec_rd) |=> ($stable(vec) && lock));

    // R8
    locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !vec_rd && !mask_wr) |=> $stable(mask));

    // R4
    rise_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!lock));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq && !lock && !mask_wr) |=> ($stable(mask) && $stable(vec) && !lock));
endmodule

bind pvic_top pvic_chk #(
    .LVL_W     (LVL_W),
    .DATA_W    (DATA_W),
    .VEC_SHIFT (VEC_SHIFT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_o),
    .irq_ack (irq_ack_i),
    .lock    (lock_w),
    .mask    (mask_w),
    .vec     (vec_w),
    .vec_rd  (rd_vec),
    .mask_wr (wr_mask)
);

// File: tb/pvic_top_test.sv
module pvic_top_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        irq;
    logic        ack = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pvic_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .irq_o        (irq),
        .irq_ack_i    (ack),
        .bus_req_i    (req),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid)
    );

    typedef struct packed {
        logic [4:0] a;
        logic [2:0] la;
        logic [4:0] b;
        logic [2:0] lb;
        logic [2:0] mask;
        logic       exp_irq;
        logic [4:0] exp_src;
    } vec_t;

    localparam vec_t TBL [0:5] = '{
        '{5'd3,  3'd2, 5'd5, 3'd6, 3'd0, 1'b1, 5'd5},
        '{5'd7,  3'd4, 5'd2, 3'd4, 3'd0, 1'b1, 5'd2},
        '{5'd1,  3'd3, 5'd9, 3'd0, 3'd0, 1'b1, 5'd1},
        '{5'd4,  3'd3, 5'd6, 3'd2, 3'd3, 1'b0, 5'd0},
        '{5'd4,  3'd5, 5'd6, 3'd2, 3'd4, 1'b1, 5'd4},
        '{5'd15, 3'd7, 5'd0, 3'd1, 3'd6, 1'b1, 5'd15}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input int word, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'(word * 4); wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int word, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 8'(word * 4);
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic cfg(input int s, input int mode, input int lvl);
        wr(16 + s, 32'((mode << 4) | lvl));
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        rd(0, v); chk("R1 vector", v, 0);
        rd(1, v); chk("R1 mask", v, 0);
        rd(3, v); chk("R1 pending", v, 0);

        // R10 acknowledge with request low is ignored
        do_ack();
        rd(0, v); chk("R10 vector", v, 0);
        rd(1, v); chk("R10 mask", v, 0);

        // R11 configuration readback: mode 2 at [5:4], level 5 at [2:0]
        cfg(6, 2, 5);
        rd(16 + 6, v); chk("R11 cfg readback", v, 32'h25);
        cfg(6, 0, 0);

        // Table: R4 R5 R7 with high-level sources
        for (int k = 0; k < 6; k++) begin
            cfg(int'(TBL[k].a), 1, int'(TBL[k].la));
            cfg(int'(TBL[k].b), 1, int'(TBL[k].lb));
            wr(1, 32'(TBL[k].mask));
            src[TBL[k].a] = 1'b1;
            src[TBL[k].b] = 1'b1;
            idle(6);
            src = '0;
            idle(3);
            chk($sformatf("R4/R5 irq vec%0d", k), 32'(irq), 32'(TBL[k].exp_irq));
            if (TBL[k].exp_irq) begin
                do_ack();
                chk($sformatf("R7 irq drop vec%0d", k), 32'(irq), 0);
                rd(0, v);
                chk($sformatf("R5/R7 vector vec%0d", k), v, 32'(TBL[k].exp_src) << 4);
                rd(1, v);
                chk($sformatf("R7 mask vec%0d", k), v,
                    32'((TBL[k].exp_src == TBL[k].a) ? TBL[k].la : TBL[k].lb));
            end
            cfg(int'(TBL[k].a), 1, 0);
            cfg(int'(TBL[k].b), 1, 0);
            wr(2, 32'hFFFF);
            wr(1, 0);
            idle(2);
        end

        // R8: higher level queued behind the lock
        cfg(3, 1, 2);
        src[3] = 1'b1; idle(6); src[3] = 1'b0; idle(3);
        do_ack();
        cfg(10, 2, 7);
        src[10] = 1'b1; idle(3); src[10] = 1'b0; idle(6);
        rd(3, v); chk("R2 rising edge pended", v, 32'h400);
        chk("R8 irq held low while locked", 32'(irq), 0);
        rd(1, v); chk("R8 mask held", v, 2);
        rd(0, v); chk("R8 vector src3", v, 32'h30);
        idle(3);
        chk("R8 irq after vector read", 32'(irq), 1);
        do_ack();
        rd(0, v); chk("R8 vector src10", v, 32'hA0);
        rd(1, v); chk("R8 mask 7", v, 7);
        wr(1, 0);
        cfg(3, 1, 0); cfg(10, 2, 0);

        // R8: mask written before vector read gives no spurious request
        cfg(2, 2, 5); cfg(11, 2, 1);
        src[2] = 1'b1; src[11] = 1'b1; idle(3); src = '0; idle(6);
        do_ack();
        wr(1, 0);
        idle(4);
        chk("R8 no spurious irq on early mask write", 32'(irq), 0);
        rd(0, v); chk("R8 vector src2", v, 32'h20);
        idle(3);
        chk("R8 lower source after read", 32'(irq), 1);
        do_ack();
        rd(0, v); chk("R8 vector src11", v, 32'hB0);
        wr(1, 0);
        cfg(2, 2, 0); cfg(11, 2, 0);

        // R6: repeated edges absorbed, acceptance clears pending
        cfg(5, 2, 3);
        src[5] = 1'b1; idle(3); src[5] = 1'b0; idle(3);
        src[5] = 1'b1; idle(3); src[5] = 1'b0; idle(6);
        do_ack();
        rd(0, v); chk("R6 vector src5", v, 32'h50);
        wr(1, 0);
        idle(4);
        chk("R6 single request", 32'(irq), 0);
        rd(3, v); chk("R6 pending cleared", v, 0);
        cfg(5, 2, 0);

        // R3: level 0 never pends; dropping to 0 clears pending
        cfg(8, 1, 0);
        src[8] = 1'b1; idle(6);
        rd(3, v); chk("R3 level0 not pending", v, 0);
        chk("R3 level0 no irq", 32'(irq), 0);
        cfg(8, 1, 3); idle(3);
        rd(3, v); chk("R3 pending after enable", v, 32'h100);
        cfg(8, 1, 0); idle(2);
        rd(3, v); chk("R3 pending dropped", v, 0);
        src[8] = 1'b0;

        // R2 low-level mode and R9 clear
        src[12] = 1'b1; idle(4);
        cfg(12, 0, 1); idle(4);
        rd(3, v); chk("R2 low mode idle high", v, 0);
        src[12] = 1'b0; idle(6);
        rd(3, v); chk("R2 low mode pended", v, 32'h1000);
        src[12] = 1'b1; idle(4);
        wr(2, 32'h1000); idle(2);
        rd(3, v); chk("R9 clear removes pending", v, 0);
        chk("R9 irq low after clear", 32'(irq), 0);
        cfg(12, 0, 0);

        // R2 falling-edge mode
        src[13] = 1'b1; idle(4);
        cfg(13, 3, 1); idle(4);
        rd(3, v); chk("R2 fall mode no edge", v, 0);
        src[13] = 1'b0; idle(6);
        rd(3, v); chk("R2 fall mode pended", v, 32'h2000);
        wr(2, 32'h2000);
        cfg(13, 3, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule